// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a software watchdog reached over an APB slave port. Software loads a 32-bit down counter and sets a run bit. From then on the counter falls by one on every bus clock. If software fails to reload the counter before it runs out, the block records the event in a status register. Depending on two enable bits, it then raises a level interrupt, a fixed-length reset request pulse, or both.

All writes that could disturb the watchdog are guarded by a 16-bit unlock register. Writes to the counter, the enable register and the status register are honoured only while that register holds 0x482E. The unlock register itself may be rewritten at any moment. Writing any other value locks the block again, and a write refused while locked is recorded in a status flag. Every register can be read back at any time.

Register offsets are byte addresses. A register is selected by paddr[3:2] and only when paddr[1:0] is 00: 0x0 counter, 0x4 enable, 0x8 unlock key, 0xC status.

Top module: `wdt_keyed`

## Requirements
- R1: After a synchronous active-low reset, the counter, enable, key and status registers read 0, and wdt_irq and wdt_rst_req are low.
- R2: A write to offset 0x8 stores pwdata[15:0] in the key register in any state, and reads back the same value. The block is unlocked exactly while the key equals 0x482E.
- R3: While locked, writes to offsets 0x0, 0x4 and 0xC leave those registers unchanged and set status bit 3 (refused write).
- R4: While enable bit 0 is 1 and the counter is non-zero, the counter falls by one each clock. At zero it holds.
- R5: A decrement from 1 to 0 is an expiry. It sets status bit 0, and also sets status bit 2 if enable bit 2 is 1. Writing 0 directly to the counter is not an expiry.
- R6: An expiry with enable bit 1 set sets status bit 1 and drives wdt_rst_req high for exactly 4 clocks, starting the cycle after the expiry edge.
- R7: wdt_irq is high exactly when status bit 0 and enable bit 2 are both 1.
- R8: While unlocked, writing 1 to any of status bits 3..0 clears that bit. An expiry in the same cycle as a clear of its bit leaves the bit set.
- R9: An unlocked counter write in the same cycle as a decrement, or as a would-be expiry, loads the written value. No expiry is recorded.
- R10: Reads return the counter at 0x0, the enable bits [2:0] at 0x4, the key [15:0] at 0xC-4 (0x8), and the status at 0xC. Status bit 4 reads 1 while counting (enable bit 0 set and counter non-zero). An access with paddr[1:0] not 00 reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock, also the count clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 4 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, selected by paddr |
| wdt_irq | output | 1 | Watchdog interrupt level |
| wdt_rst_req | output | 1 | Watchdog reset request pulse |

## Verification
Two functions can act on the same register in the same clock: software access and the count engine. The first case is a status clear that lands on the very edge where the counter reaches zero. The second is a counter reload that lands on the edge where the counter would otherwise expire. Both are provoked by issuing two APB writes back to back, so that the second access edge falls exactly two clocks after a load of 2. The bench then reads back the status and the counter. It compares them with a behavioural model that applies "set wins over clear" and "load wins over decrement".

// File: rtl/wdt_pkg.sv
// Shared constants and types of the key-protected watchdog.
// Assumes a 32-bit APB data path and a 16-byte register window.
package wdt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int KEY_W  = 16;
    localparam int EN_W   = 3;
    localparam int STS_W  = 5;
    localparam int FLG_W  = STS_W - 1;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h482E;

    // enable bit positions
    localparam int EN_RUN = 0;
    localparam int EN_RST = 1;
    localparam int EN_IRQ = 2;

    // status bit positions
    localparam int ST_EXP  = 0;
    localparam int ST_RST  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_DROP = 3;
    localparam int ST_RUN  = 4;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_KEY    = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic count;
        logic enable;
        logic status;
        logic refused;
    } wr_strobe_t;
endpackage

// File: rtl/wdt_apb_regs.sv
// APB decode, unlock key and enable register of the watchdog.
// Assumes a zero-wait-state slave; a write takes effect on the access edge.
// Only word-aligned addresses select a register.
module wdt_apb_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                    pclk,
    input  logic                    presetn,
    input  logic                    psel,
    input  logic                    penable,
    input  logic                    pwrite,
    input  logic [ADDR_W-1:0]       paddr,
    input  logic [KEY_W-1:0]        wr_data,
    input  logic [CNT_W-1:0]        count_q,
    input  logic [STS_W-1:0]        sts_q,
    output logic [DATA_W-1:0]       prdata,
    output logic [EN_W-1:0]         en_q,
    output logic [KEY_W-1:0]        key_q,
    output wr_strobe_t              wr
);
    logic     aligned;
    logic     wr_hit;
    logic     unlocked;
    logic     guarded;
    reg_sel_e sel;

    // decode the access phase of a write into a register selection
    always_comb begin
        aligned  = (paddr[1:0] == 2'b00);
        sel      = reg_sel_e'(paddr[3:2]);
        wr_hit   = psel && penable && pwrite && aligned;
        unlocked = (key_q == UNLOCK_KEY);
        guarded  = wr_hit && (sel != REG_KEY);
    end

    // gate protected write strobes with the unlock state
    always_comb begin
        wr.count   = guarded && unlocked && (sel == REG_COUNT);
        wr.enable  = guarded && unlocked && (sel == REG_ENABLE);
        wr.status  = guarded && unlocked && (sel == REG_STATUS);
        wr.refused = guarded && !unlocked;
    end

    // key register: writable in every state
    always_ff @(posedge pclk) begin
        if (!presetn)
            key_q <= '0;
        else if (wr_hit && (sel == REG_KEY))
            key_q <= wr_data;
    end

    // enable register: writable only when unlocked
    always_ff @(posedge pclk) begin
        if (!presetn)
            en_q <= '0;
        else if (wr.enable)
            en_q <= wr_data[EN_W-1:0];
    end

    // read multiplexer, valid whenever paddr is stable
    always_comb begin
        prdata = '0;
        if (aligned) begin
            case (sel)
                REG_COUNT:  prdata = DATA_W'(count_q);
                REG_ENABLE: prdata = DATA_W'(en_q);
                REG_KEY:    prdata = DATA_W'(key_q);
                REG_STATUS: prdata = DATA_W'(sts_q);
                default:    prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_down_counter.sv
// Loadable down counter of the watchdog with expiry detection.
// Assumes the load request already carries the unlock qualification.
// A load in the same cycle as a decrement wins and cancels any expiry.
module wdt_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             pclk,
    input  logic             presetn,
    input  logic             run_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // running and expiry qualifiers from the current count
    always_comb begin
        running = run_en && (count_q != '0);
        expire  = running && (count_q == ONE) && !load;
    end

    // count register: load first, then decrement while running
    always_ff @(posedge pclk) begin
        if (!presetn)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (running)
            count_q <= count_q - ONE;
    end
endmodule

// File: rtl/wdt_status_flags.sv
// Sticky status flags with write-one-to-clear.
// Assumes the clear request already carries the unlock qualification.
// A set and a clear of the same bit in one cycle leave the bit set.
module wdt_status_flags
    import wdt_pkg::*;
(
    input  logic             pclk,
    input  logic             presetn,
    input  logic [FLG_W-1:0] set_vec,
    input  logic             clr_we,
    input  logic [FLG_W-1:0] clr_mask,
    input  logic             running,
    output logic [STS_W-1:0] sts_q
);
    logic [FLG_W-1:0] flags_q;
    logic [FLG_W-1:0] clr_eff;

    // effective clear mask for this cycle
    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
    end

    // sticky flags: clear, then set, so set has priority
    always_ff @(posedge pclk) begin
        if (!presetn)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~clr_eff) | set_vec;
    end

    // live running indication on top of the sticky flags
    always_comb begin
        sts_q = {running, flags_q};
    end
endmodule

// File: rtl/wdt_pulse_gen.sv
// Fixed-length pulse generator for the reset request.
// Assumes LEN >= 1; a trigger while active restarts the full length.
module wdt_pulse_gen #(
    parameter int LEN = 4
) (
    input  logic pclk,
    input  logic presetn,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_V = CW'(LEN);

    logic [CW-1:0] left_q;

    // remaining pulse cycles
    always_ff @(posedge pclk) begin
        if (!presetn)
            left_q <= '0;
        else if (trig)
            left_q <= LEN_V;
        else if (left_q != '0)
            left_q <= left_q - CW'(1);
    end

    // pulse is high while cycles remain
    always_comb begin
        pulse = (left_q != '0);
    end
endmodule

// File: rtl/wdt_keyed.sv
// Top of the key-protected watchdog timer.
// Joins the APB register file, the down counter, the status flags and
// the reset pulse generator. Counts on pclk with no prescaling.
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RST_LEN = 4
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              wdt_irq,
    output logic              wdt_rst_req
);
    logic [EN_W-1:0]  en_q;
    logic [KEY_W-1:0] key_q;
    logic [CNT_W-1:0] count_q;
    logic [STS_W-1:0] sts_q;
    logic [FLG_W-1:0] set_vec;
    logic             running;
    logic             expire;
    logic             rst_trig;
    wr_strobe_t       wr;

    wdt_apb_regs #(.CNT_W(CNT_W)) u_regs (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wr_data (pwdata[KEY_W-1:0]),
        .count_q (count_q),
        .sts_q   (sts_q),
        .prdata  (prdata),
        .en_q    (en_q),
        .key_q   (key_q),
        .wr      (wr)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .pclk     (pclk),
        .presetn  (presetn),
        .run_en   (en_q[EN_RUN]),
        .load     (wr.count),
        .load_val (pwdata[CNT_W-1:0]),
        .count_q  (count_q),
        .running  (running),
        .expire   (expire)
    );

    // flag set sources for this cycle
    always_comb begin
        set_vec          = '0;
        set_vec[ST_EXP]  = expire;
        set_vec[ST_RST]  = expire && en_q[EN_RST];
        set_vec[ST_IRQ]  = expire && en_q[EN_IRQ];
        set_vec[ST_DROP] = wr.refused;
        rst_trig         = expire && en_q[EN_RST];
    end

    wdt_status_flags u_sts (
        .pclk     (pclk),
        .presetn  (presetn),
        .set_vec  (set_vec),
        .clr_we   (wr.status),
        .clr_mask (pwdata[FLG_W-1:0]),
        .running  (running),
        .sts_q    (sts_q)
    );

    wdt_pulse_gen #(.LEN(RST_LEN)) u_rst (
        .pclk    (pclk),
        .presetn (presetn),
        .trig    (rst_trig),
        .pulse   (wdt_rst_req)
    );

    // interrupt level from pending expiry and its enable
    always_comb begin
        wdt_irq = sts_q[ST_EXP] && en_q[EN_IRQ];
    end
endmodule

// Protocol checker bound to the watchdog top.
module wdt_keyed_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RST_LEN = 4
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [KEY_W-1:0]  key_wdata,
    input logic [KEY_W-1:0]  key_q,
    input logic [EN_W-1:0]   en_q,
    input logic [CNT_W-1:0]  count_q,
    input logic [1:0]        sts_flag,
    input logic              wdt_rst_req
);
    logic        acc;
    int unsigned hi_run;

    always_comb acc = psel && penable && pwrite && (paddr[1:0] == 2'b00);

    // consecutive cycles of reset request seen so far
    always_ff @(posedge pclk) begin
        if (!presetn)
            hi_run <= 0;
        else if (wdt_rst_req)
            hi_run <= hi_run + 1;
        else
            hi_run <= 0;
    end

    // R2
    key_any_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (acc && paddr[3:2] == 2'd2) |=> (key_q == $past(key_wdata)));

    // R3
    lock_en_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (acc && paddr[3:2] == 2'd1 && key_q != UNLOCK_KEY) |=> $stable(en_q));

    // R4
    zero_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (count_q == '0 && !(acc && paddr[3:2] == 2'd0)) |=> (count_q == '0));

    // R5
    exp_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(sts_flag[0]) |-> (count_q == '0));

    // R6
    rst_flag_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(wdt_rst_req) |-> sts_flag[1]);

    // R6
    rst_len_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $fell(wdt_rst_req) |-> (hi_run >= RST_LEN));
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
    .pclk        (pclk),
    .presetn     (presetn),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .key_wdata   (pwdata[15:0]),
    .key_q       (key_q),
    .en_q        (en_q),
    .count_q     (count_q),
    .sts_flag    (sts_q[1:0]),
    .wdt_rst_req (wdt_rst_req)
);

// File: tb/wdt_keyed_tb.sv
// Bench for the key-protected watchdog: behavioural model compared every
// clock, plus directed checks with literal expectations.
module wdt_keyed_tb;
    logic        clk = 1'b0;
    logic        presetn;
    logic        psel, penable, pwrite;
    logic [3:0]  paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        irq, rst;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    wdt_keyed u_dut (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .wdt_irq(irq), .wdt_rst_req(rst)
    );

    // behavioural model state
    logic [31:0] m_cnt;
    logic [2:0]  m_en;
    logic [15:0] m_key;
    logic [3:0]  m_flg;
    int          m_pulse;

    always @(posedge clk) begin : model
        logic acc, unl, run, ex, lw;
        logic [1:0] a;
        logic [3:0] clr, setv;
        if (!presetn) begin
            m_cnt = 0; m_en = 0; m_key = 0; m_flg = 0; m_pulse = 0;
        end else begin
            acc  = psel && penable && pwrite && (paddr[1:0] == 2'b00);
            a    = paddr[3:2];
            unl  = (m_key == 16'h482E);
            run  = m_en[0] && (m_cnt != 0);
            lw   = acc && a == 2'd0 && unl;
            ex   = run && (m_cnt == 1) && !lw;
            clr  = (acc && a == 2'd3 && unl) ? pwdata[3:0] : 4'h0;
            setv = {acc && a != 2'd2 && !unl, ex && m_en[2], ex && m_en[1], ex};
            m_flg = (m_flg & ~clr) | setv;
            if (ex && m_en[1]) m_pulse = 4;
            else if (m_pulse > 0) m_pulse--;
            if (lw) m_cnt = pwdata;
            else if (run) m_cnt = m_cnt - 1;
            if (acc && a == 2'd1 && unl) m_en = pwdata[2:0];
            if (acc && a == 2'd2) m_key = pwdata[15:0];
        end
    end

    function automatic logic [31:0] model_rd(input logic [3:0] ad);
        if (ad[1:0] != 2'b00) return 32'h0;
        case (ad[3:2])
            2'd0:    return m_cnt;
            2'd1:    return {29'h0, m_en};
            2'd2:    return {16'h0, m_key};
            default: return {27'h0, (m_en[0] && m_cnt != 0), m_flg};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (presetn === 1'b1) begin
            check("R10 readback vs model", prdata, model_rd(paddr));
            check("R7 irq vs model", {31'h0, irq}, {31'h0, m_flg[0] && m_en[2]});
            check("R6 rst_req vs model", {31'h0, rst}, {31'h0, m_pulse > 0});
        end
    end

    // watchdog of the bench
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr_raw(input logic [3:0] ad, input logic [31:0] d);
        @(negedge clk); #1;
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = ad; pwdata = d;
        @(negedge clk); #1;
        penable = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [3:0] ad, input logic [31:0] d);
        wr_raw(ad, d);
        idle();
    endtask

    task automatic peek(input logic [3:0] ad, output logic [31:0] v);
        @(negedge clk); #1;
        paddr = ad;
        @(negedge clk);
        v = prdata;
    endtask

    localparam logic [3:0] A_CNT = 4'h0, A_EN = 4'h4, A_KEY = 4'h8, A_STS = 4'hC;

    initial begin
        logic [31:0] v;
        int highs;
        presetn = 1'b0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
        repeat (5) @(negedge clk);
        #1 presetn = 1'b1;

        // R1 reset state
        peek(A_CNT, v); check("R1 count", v, 0);
        peek(A_EN,  v); check("R1 enable", v, 0);
        peek(A_KEY, v); check("R1 key", v, 0);
        peek(A_STS, v); check("R1 status", v, 0);
        check("R1 outputs", {30'h0, irq, rst}, 0);

        // R3 locked writes dropped and flagged
        wr(A_CNT, 100);
        peek(A_CNT, v); check("R3 locked count", v, 0);
        peek(A_STS, v); check("R3 refused flag", v, 32'h08);
        wr(A_KEY, 32'hABCD_1234);
        peek(A_KEY, v); check("R2 key any value", v, 32'h1234);
        wr(A_EN, 7);
        peek(A_EN, v); check("R3 locked enable", v, 0);

        // R10 misaligned access
        wr(4'hA, 32'h482E);
        peek(A_KEY, v); check("R10 misaligned write", v, 32'h1234);
        peek(4'h5, v); check("R10 misaligned read", v, 0);

        // R2 unlock
        wr(A_KEY, 32'h482E);
        peek(A_KEY, v); check("R2 unlock key", v, 32'h482E);
        wr(A_STS, 32'h1F);
        peek(A_STS, v); check("R8 clear refused", v, 0);

        // R4 decrement per clock
        wr(A_EN, 1);
        wr_raw(A_CNT, 1000);
        wr_raw(A_EN, 0);
        idle();
        peek(A_CNT, v); check("R4 decrement", v, 998);

        // R9 load wins over expiry
        wr(A_CNT, 0);
        wr(A_EN, 1);
        wr_raw(A_CNT, 2);
        wr_raw(A_CNT, 32'h50);
        wr_raw(A_EN, 0);
        idle();
        peek(A_CNT, v); check("R9 load wins", v, 32'h4E);
        peek(A_STS, v); check("R9 no expiry", v, 0);

        // R8 set wins over clear on the expiry edge
        wr(A_CNT, 0);
        wr(A_EN, 1);
        wr_raw(A_CNT, 2);
        wr_raw(A_STS, 1);
        idle();
        peek(A_STS, v); check("R8 set wins", v, 32'h01);
        wr(A_STS, 1);
        peek(A_STS, v); check("R8 clear", v, 0);

        // R5 expiry versus direct zero write
        wr(A_CNT, 0);
        peek(A_STS, v); check("R5 zero write no expiry", v, 0);
        wr(A_CNT, 10);
        repeat (20) @(negedge clk);
        peek(A_CNT, v); check("R4 hold at zero", v, 0);
        peek(A_STS, v); check("R5 expiry flag", v, 32'h01);
        check("R7 irq masked", {31'h0, irq}, 0);
        wr(A_EN, 4);
        check("R7 irq enabled", {31'h0, irq}, 1);
        wr(A_STS, 1);
        check("R8 irq cleared", {31'h0, irq}, 0);

        // R6 reset pulse length
        wr(A_CNT, 3);
        wr(A_EN, 3);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rst) highs++;
        end
        check("R6 pulse length", highs, 4);
        peek(A_STS, v); check("R6 status", v, 32'h03);

        // R3 relock
        wr(A_KEY, 0);
        wr(A_EN, 7);
        peek(A_EN, v); check("R3 relocked enable", v, 3);
        peek(A_STS, v); check("R3 relocked status", v, 32'h0B);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule